// File: doc/BRIEF.md
# Segmented-Carry Approximate Adder

This block adds two unsigned operands by splitting them into equal-width segments, each summed by its own small adder. No carry ripples from one segment to the next. Each segment's carry-in comes from a short carry predictor that looks only at a limited window of lower operand bits and assumes a zero carry below that window. Cutting the chain this way shortens the worst-case path. The cost is an occasional wrong result when a carry would have had to travel further than the window reaches.

A build-time mode selects the window sizes. In the local mode, every segment above the lowest one takes its carry from the single segment directly beneath it. In the cascaded mode, the predictors for the upper segments are chained, so the top segment sees a longer span than the one below it. With the defaults (4-bit segments, four segments, chain depth 3), the top segment's carry covers the 12 bits below it and the next segment's carry covers 8 bits. The default cascaded build therefore gives the exact sum. Wider builds keep the lower segments on the short local window. The block is purely combinational and suits datapaths such as media filters that tolerate small errors in exchange for speed.

Top module: `segmented_approx_adder`

## Requirements
- R1: The lowest segment (sum bits 3:0 by default) always uses carry-in 0, so those bits equal the low bits of the sum of the lowest operand segments.
- R2: In local mode, the carry into segment k (k ≥ 1) is the carry-out of adding only segment k-1's operand bits with carry-in 0; 0x00FF + 0x0001 therefore gives 0x00000.
- R3: A segment whose own operands produce a carry passes it to the segment above: 0x000F + 0x000F gives exactly 0x001E in both modes.
- R4: In cascaded mode, the top segment's carry-in is the exact carry out of the CHAIN_DEPTH segments below it (12 bits by default).
- R5: In cascaded mode, the second-highest segment's carry-in is the exact carry out of the CHAIN_DEPTH-1 segments below it (8 bits by default).
- R6: With the default parameters in cascaded mode, the result equals the exact sum A + B for all inputs.
- R7: The most significant sum bit (bit 16 by default) is the carry-out of the top segment's adder: 0xFFFF + 0x0001 gives 0x10000 in cascaded mode and 0x0FF00 in local mode.
- R8: The result never exceeds the exact sum, and each segment's sum field equals its operand segments plus its carry-in, modulo 16.
- R9: In a wider cascaded build (8 segments), the segments below the second-highest use only the local one-segment window: 0x000000FF + 0x00000001 gives 0, while 0x0FF00000 + 0x00100000 gives the exact 0x10000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SEG_W*NUM_SEG (16) | First unsigned operand |
| b_i | input | SEG_W*NUM_SEG (16) | Second unsigned operand |
| sum_o | output | SEG_W*NUM_SEG+1 (17) | Approximate sum; the top bit is the top segment's carry-out |

## Verification
In any single evaluation, a lower segment can lose a carry on its short local window while an upper segment receives the same carry exactly through the cascaded span. Both effects then show up in one output word. The bench provokes this on an 8-segment cascaded build. It uses operand pairs whose carry starts in the low half, and pairs whose carry starts just under the top three segments. Each result is judged against a bench-side model of the window rules and against literal expected words. The same operand pairs also go to a local-mode build, which shows where the two modes diverge.

// File: rtl/segadd_pkg.sv
// Package: shared mode type and the carry-window rule for the segmented adder.
// Assumes: segment index 0 is the least significant segment.
package segadd_pkg;

    typedef enum logic {
        CARRY_LOCAL   = 1'b0,
        CARRY_CASCADE = 1'b1
    } carry_mode_e;

    // Number of lower segments whose bits feed the carry into segment seg.
    function automatic int carry_span(input int seg, input int nseg,
                                      input int depth, input carry_mode_e mode);
        int span;
        if (seg == 0) return 0;
        span = 1;
        if (mode == CARRY_CASCADE) begin
            if ((nseg - 1 - seg) < (depth - 1)) span = depth - (nseg - 1 - seg);
        end
        if (span > seg) span = seg;
        if (span < 1) span = 1;
        return span;
    endfunction

endpackage

// File: rtl/carry_lookahead_gen.sv
// Module: group carry generator for one segment.
// Computes the segment's group generate and propagate terms and returns
// generate OR (propagate AND carry-in). It produces no sum bits.
// Assumes: operands are unsigned, and SEG_W >= 1.
module carry_lookahead_gen #(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    input  logic             cin_i,
    output logic             cout_o
);

    logic [SEG_W-1:0] bit_gen;
    logic [SEG_W-1:0] bit_prop;
    logic             grp_gen;
    logic             grp_prop;

    // Per-bit generate and propagate terms.
    assign bit_gen  = a_i & b_i;
    assign bit_prop = a_i ^ b_i;

    // Fold the bit terms into the group generate and group propagate.
    always_comb begin
        grp_gen  = 1'b0;
        grp_prop = 1'b1;
        for (int i = 0; i < SEG_W; i++) begin
            grp_gen  = bit_gen[i] | (bit_prop[i] & grp_gen);
            grp_prop = grp_prop & bit_prop[i];
        end
    end

    // Carry-out of the segment.
    assign cout_o = grp_gen | (grp_prop & cin_i);

endmodule

// File: rtl/carry_span_chain.sv
// Module: cascade of SPAN group carry generators.
// The bottom generator has carry-in 0. The output is the carry out of the
// whole SPAN*SEG_W-bit window.
// Assumes: SPAN >= 1, and the window's LSB is its bit 0.
module carry_span_chain #(
    parameter int SEG_W = 4,
    parameter int SPAN  = 1
) (
    input  logic [SPAN*SEG_W-1:0] a_i,
    input  logic [SPAN*SEG_W-1:0] b_i,
    output logic                  carry_o
);

    localparam int WIN_W = SPAN * SEG_W;

    logic [SPAN:0] link;

    assign link[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < SPAN; k++) begin : g_stage
            carry_lookahead_gen #(.SEG_W(SEG_W)) u_gen (
                .a_i   (a_i[k*SEG_W +: SEG_W]),
                .b_i   (b_i[k*SEG_W +: SEG_W]),
                .cin_i (link[k]),
                .cout_o(link[k+1])
            );
        end
    endgenerate

    assign carry_o = link[SPAN];

    // Check: the chained carry equals the arithmetic carry of the window (R2, R4, R5).
    always_comb begin
        logic [WIN_W:0] win_sum;
        win_sum = {1'b0, a_i} + {1'b0, b_i};
        assert_window_carry_R4: assert (carry_o == win_sum[WIN_W])
            else $error("window carry mismatch");
    end

endmodule

// File: rtl/seg_sum_cell.sv
// Module: SEG_W-bit ripple adder for a single segment.
// Assumes: the carry-in is supplied by a carry predictor outside this cell.
module seg_sum_cell #(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W-1:0] a_i,
    input  logic [SEG_W-1:0] b_i,
    input  logic             cin_i,
    output logic [SEG_W-1:0] sum_o,
    output logic             cout_o
);

    logic [SEG_W:0] rip;

    // Full-adder ripple inside the segment.
    always_comb begin
        rip[0] = cin_i;
        for (int i = 0; i < SEG_W; i++) begin
            sum_o[i]  = a_i[i] ^ b_i[i] ^ rip[i];
            rip[i+1]  = (a_i[i] & b_i[i]) | (rip[i] & (a_i[i] ^ b_i[i]));
        end
    end

    assign cout_o = rip[SEG_W];

    // Check: the segment result is the modular sum of its inputs and carry-in (R8).
    always_comb begin
        logic [SEG_W:0] ref_seg;
        ref_seg = {1'b0, a_i} + {1'b0, b_i} + {{SEG_W{1'b0}}, cin_i};
        assert_seg_arith_R8: assert ({cout_o, sum_o} == ref_seg)
            else $error("segment sum mismatch");
    end

endmodule

// File: rtl/segmented_approx_adder.sv
// Module: segmented-carry approximate adder (top).
// Splits the operands into NUM_SEG segments of SEG_W bits each. A window
// predictor from segadd_pkg::carry_span provides each segment's carry-in.
// The top segment's carry-out becomes the MSB of the sum.
// Assumes: unsigned operands; CHAIN_DEPTH >= 1; purely combinational.
module segmented_approx_adder #(
    parameter int                       SEG_W       = 4,
    parameter int                       NUM_SEG     = 4,
    parameter int                       CHAIN_DEPTH = 3,
    parameter segadd_pkg::carry_mode_e  MODE        = segadd_pkg::CARRY_CASCADE
) (
    input  logic [SEG_W*NUM_SEG-1:0] a_i,
    input  logic [SEG_W*NUM_SEG-1:0] b_i,
    output logic [SEG_W*NUM_SEG:0]   sum_o
);

    localparam int TOTAL_W = SEG_W * NUM_SEG;
    localparam bit FULL_REACH = (MODE == segadd_pkg::CARRY_CASCADE) &&
                                (NUM_SEG <= CHAIN_DEPTH + 1);

    logic [NUM_SEG-1:0] seg_cin;
    logic [NUM_SEG-1:0] seg_cout;
    logic [TOTAL_W-1:0] sum_bits;

    // The lowest segment never receives a carry.
    assign seg_cin[0] = 1'b0;

    genvar s;
    generate
        for (s = 1; s < NUM_SEG; s++) begin : g_carry
            localparam int SPAN = segadd_pkg::carry_span(s, NUM_SEG, CHAIN_DEPTH, MODE);
            localparam int LO   = (s - SPAN) * SEG_W;

            carry_span_chain #(.SEG_W(SEG_W), .SPAN(SPAN)) u_chain (
                .a_i    (a_i[s*SEG_W-1:LO]),
                .b_i    (b_i[s*SEG_W-1:LO]),
                .carry_o(seg_cin[s])
            );

            // Check: a predicted carry implies the real carry-out of the segment below (R2).
            always_comb begin
                assert_cin_implies_cout_R2: assert (!seg_cin[s] || seg_cout[s-1] || SPAN > 1)
                    else $error("predicted carry without lower carry-out");
            end
        end

        for (s = 0; s < NUM_SEG; s++) begin : g_sum
            seg_sum_cell #(.SEG_W(SEG_W)) u_cell (
                .a_i   (a_i[s*SEG_W +: SEG_W]),
                .b_i   (b_i[s*SEG_W +: SEG_W]),
                .cin_i (seg_cin[s]),
                .sum_o (sum_bits[s*SEG_W +: SEG_W]),
                .cout_o(seg_cout[s])
            );
        end
    endgenerate

    // Assemble the result; the MSB is the top segment's carry-out.
    assign sum_o = {seg_cout[NUM_SEG-1], sum_bits};

    // Checks of the whole-word behaviour against the exact sum (R1, R6, R7, R8).
    always_comb begin
        logic [TOTAL_W:0] exact_sum;
        logic [SEG_W:0]   low_sum;
        exact_sum = {1'b0, a_i} + {1'b0, b_i};
        low_sum   = {1'b0, a_i[SEG_W-1:0]} + {1'b0, b_i[SEG_W-1:0]};
        assert_low_segment_R1: assert (sum_o[SEG_W-1:0] == low_sum[SEG_W-1:0])
            else $error("lowest segment not exact");
        assert_never_above_exact_R8: assert (sum_o <= exact_sum)
            else $error("result above exact sum");
        assert_msb_needs_real_carry_R7: assert (!sum_o[TOTAL_W] || exact_sum[TOTAL_W])
            else $error("MSB set without an exact carry");
        if (FULL_REACH) begin
            assert_full_reach_exact_R6: assert (sum_o == exact_sum)
                else $error("cascaded build not exact");
        end
    end

endmodule

// File: tb/segmented_approx_adder_tb.sv
// Directed bench: one task per scenario. Three builds are compared with a
// bench-side model of the window rules.
module segmented_approx_adder_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [15:0] a16, b16;
    logic [31:0] a32, b32;
    logic [16:0] sum_casc, sum_plain;
    logic [32:0] sum_wide;

    segmented_approx_adder u_dut (
        .a_i(a16), .b_i(b16), .sum_o(sum_casc)
    );

    segmented_approx_adder #(.MODE(segadd_pkg::CARRY_LOCAL)) u_dut_plain (
        .a_i(a16), .b_i(b16), .sum_o(sum_plain)
    );

    segmented_approx_adder #(.NUM_SEG(8)) u_dut_wide (
        .a_i(a32), .b_i(b32), .sum_o(sum_wide)
    );

    // Model written from the requirements: window span per segment, zero carry below it.
    function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input int nseg, input bit casc);
        logic [32:0] r;
        r = '0;
        for (int s = 0; s < nseg; s++) begin
            int          span;
            logic [63:0] ma, mb, lsum, mask;
            logic        c;
            logic [4:0]  seg;
            span = (s == 0) ? 0 : 1;
            if (casc && s > 0 && (nseg - 1 - s) < 2) span = 3 - (nseg - 1 - s);
            if (span > s) span = s;
            c = 1'b0;
            if (span > 0) begin
                mask = (64'd1 << (span * 4)) - 64'd1;
                ma   = (64'(a) >> ((s - span) * 4)) & mask;
                mb   = (64'(b) >> ((s - span) * 4)) & mask;
                lsum = ma + mb;
                c    = lsum[span * 4];
            end
            seg = 5'(a[s*4 +: 4]) + 5'(b[s*4 +: 4]) + 5'(c);
            r[s*4 +: 4] = seg[3:0];
            if (s == nseg - 1) r[nseg*4] = seg[4];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply16(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        a16 = a;
        b16 = b;
        #2;
    endtask

    task automatic apply32(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        a32 = a;
        b32 = b;
        #2;
    endtask

    // Zero operands: both builds give zero; the lowest segment is exact (R1).
    task automatic test_idle_state();
        apply16(16'h0000, 16'h0000);
        chk("R1 idle cascaded", 64'(sum_casc), 64'h0);
        chk("R1 idle local", 64'(sum_plain), 64'h0);
        apply16(16'h0009, 16'h0008);
        chk("R1 low segment local", 64'(sum_plain[3:0]), 64'h1);
    endtask

    // A generated carry reaches the next segment (R3).
    task automatic test_generate_pass();
        apply16(16'h000F, 16'h000F);
        chk("R3 local 0x000F+0x000F", 64'(sum_plain), 64'h001E);
        chk("R3 cascaded 0x000F+0x000F", 64'(sum_casc), 64'h001E);
    endtask

    // Local mode drops a carry that must cross two segments (R2).
    task automatic test_local_drop();
        apply16(16'h00FF, 16'h0001);
        chk("R2 local 0x00FF+0x0001", 64'(sum_plain), 64'h00000);
        chk("R5 cascaded 0x00FF+0x0001", 64'(sum_casc), 64'h00100);
        apply16(16'h0FF0, 16'h0010);
        chk("R2 local 0x0FF0+0x0010", 64'(sum_plain), 64'h00000);
        chk("R4 cascaded 0x0FF0+0x0010", 64'(sum_casc), 64'h01000);
    endtask

    // The MSB is the top segment's carry-out (R7).
    task automatic test_top_carry();
        apply16(16'hFFFF, 16'h0001);
        chk("R7 cascaded 0xFFFF+0x0001", 64'(sum_casc), 64'h10000);
        chk("R7 local 0xFFFF+0x0001", 64'(sum_plain), 64'h0FF00);
        apply16(16'h8000, 16'h8000);
        chk("R7 local 0x8000+0x8000", 64'(sum_plain), 64'h10000);
    endtask

    // Random sweep: the cascaded build is exact; the local build follows the model and never exceeds the exact sum (R6, R8).
    task automatic test_sweep();
        for (int n = 0; n < 300; n++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            apply16(ra, rb);
            chk("R6 cascaded exact", 64'(sum_casc), 64'({1'b0, ra} + {1'b0, rb}));
            chk("R8 local model", 64'(sum_plain), 64'(model(32'(ra), 32'(rb), 4, 1'b0)));
            if (sum_plain > ({1'b0, ra} + {1'b0, rb}))
                chk("R8 local not above exact", 64'(sum_plain), 64'({1'b0, ra} + {1'b0, rb}));
        end
    endtask

    // Wide cascaded build: short windows low, long windows for the top two segments (R9, R4, R5).
    task automatic test_wide();
        apply32(32'h000000FF, 32'h00000001);
        chk("R9 wide low carry lost", 64'(sum_wide), 64'h0);
        apply32(32'h0FF00000, 32'h00100000);
        chk("R4 wide 12-bit window", 64'(sum_wide), 64'h10000000);
        apply32(32'h00F00000, 32'h00100000);
        chk("R5 wide 8-bit window", 64'(sum_wide), 64'h01000000);
        apply32(32'hFFFFFFFF, 32'h00000001);
        chk("R9 wide all ones", 64'(sum_wide), 64'(model(32'hFFFFFFFF, 32'h1, 8, 1'b1)));
        for (int n = 0; n < 200; n++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            apply32(ra, rb);
            chk("R9 wide model", 64'(sum_wide), 64'(model(ra, rb, 8, 1'b1)));
        end
    endtask

    initial begin
        a16 = '0; b16 = '0; a32 = '0; b32 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        test_idle_state();
        test_generate_pass();
        test_local_drop();
        test_top_carry();
        test_sweep();
        test_wide();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule